// File: doc/BRIEF.md
# Power Mode Control Register

This block is the byte-wide power-control register of a small 8-bit microcontroller core, together with the logic that turns its contents into control signals. Software writes the whole byte through a special-function-register style port. The byte holds a baud-doubling bit, two general-purpose flags, a power-down request and an idle request. The block decodes these into two mutually exclusive mode outputs. The idle output tells the clock controller to gate only the CPU clock. The power-down output tells it to stop every clock.

An enabled interrupt, reported on a single wake input, ends idle. Power-down is left only through reset. The block also gives the serial-port baud generator a divide-select signal. That signal requests double speed only when the doubling bit is set, timer 1 is the baud source and the serial port is in a mode other than 0.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, rd_data reads 0x00 and idle_mode, pd_mode and baud_x2 are all low.
- R2: A write (reg_sel and wr_en high at a clock edge) stores wr_data bit 7 (double-rate), bit 3 (flag 1) and bit 2 (flag 0). From the next cycle these read back at the same bit positions of rd_data.
- R3: rd_data bits 6 to 4 always read 0, whatever value was written to them.
- R4: A write with bit 0 = 1 and bit 1 = 0 raises idle_mode and rd_data bit 0 from the next cycle. A later write with bit 0 = 0 clears them.
- R5: A write with bit 1 = 1 raises pd_mode and rd_data bit 1 from the next cycle.
- R6: A write with both bit 1 and bit 0 set enters power-down only. idle_mode stays low and rd_data bit 0 reads 0.
- R7: wake_irq high at a clock edge clears the idle request (rd_data bit 0) and idle_mode from the next cycle. This also holds when a write sets bit 0 in the same cycle.
- R8: Once set, pd_mode and rd_data bit 1 stay high until reset, whether wake_irq is high or a later write has bit 1 = 0.
- R9: idle_mode and pd_mode are never both high.
- R10: baud_x2 is high exactly when the stored double-rate bit is 1, t1_baud_src is 1 and ser_mode is not 0.
- R11: A clock edge with reg_sel or wr_en low changes nothing the register holds, unless wake_irq clears the idle request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Selects this register on the SFR port |
| wr_en | input | 1 | Whole-byte write strobe |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Current register contents |
| wake_irq | input | 1 | An enabled interrupt is pending |
| ser_mode | input | SER_MODE_W | Serial port operating mode (0 to 3) |
| t1_baud_src | input | 1 | Timer 1 is the baud source |
| idle_mode | output | 1 | Gate the CPU clock only |
| pd_mode | output | 1 | Stop all clocks |
| baud_x2 | output | 1 | Baud generator divides by half |

## Verification
The bench builds the block with its default SER_MODE_W of 2. With that width it can drive all four serial modes, so the mode-0 exception to baud doubling and the three doubling modes are each reached. Every pairing of the double-rate bit with the timer-source input is also reached. The stimulus steps through the collisions that decide the mode outputs: both request bits set in one write, a wake arriving in the same cycle as an idle write, and wake or zero writes while in power-down. A mid-run reset shows that power-down is left only through reset.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
    localparam int BYTE_W  = 8;
    localparam int POS_DBL = 7;
    localparam int POS_GF1 = 3;
    localparam int POS_GF0 = 2;
    localparam int POS_PD  = 1;
    localparam int POS_IDL = 0;

    typedef struct packed {
        logic dbl;
        logic gf1;
        logic gf0;
        logic pd;
        logic idl;
    } pmc_state_t;

    localparam pmc_state_t PMC_RESET = '{dbl: 1'b0, gf1: 1'b0, gf0: 1'b0, pd: 1'b0, idl: 1'b0};
endpackage

// File: rtl/pwr_mode_out.sv
module pwr_mode_out
    import pwr_mode_pkg::*;
(
    input  pmc_state_t st,
    output logic       idle_mode,
    output logic       pd_mode
);
    // power-down dominates idle in the decode as well as in the register
    always_comb begin
        pd_mode   = st.pd;
        idle_mode = st.idl & ~st.pd;
    end
endmodule

// File: rtl/pwr_baud_sel.sv
module pwr_baud_sel #(
    parameter int SER_MODE_W = 2
) (
    input  logic                  dbl,
    input  logic                  t1_src,
    input  logic [SER_MODE_W-1:0] ser_mode,
    output logic                  x2
);
    localparam logic [SER_MODE_W-1:0] SHIFT_MODE = '0;

    always_comb begin
        x2 = dbl & t1_src & (ser_mode != SHIFT_MODE);
    end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
    import pwr_mode_pkg::*;
#(
    parameter int SER_MODE_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_sel,
    input  logic                  wr_en,
    input  logic [7:0]            wr_data,
    output logic [7:0]            rd_data,
    input  logic                  wake_irq,
    input  logic [SER_MODE_W-1:0] ser_mode,
    input  logic                  t1_baud_src,
    output logic                  idle_mode,
    output logic                  pd_mode,
    output logic                  baud_x2
);
    localparam int RSV_LO = POS_GF1 + 1;
    localparam int RSV_HI = POS_DBL - 1;

    pmc_state_t st_d, st_q;
    logic       wr_hit;

    always_comb begin
        wr_hit = reg_sel & wr_en;
        st_d   = st_q;
        if (wr_hit) begin
            st_d.dbl = wr_data[POS_DBL];
            st_d.gf1 = wr_data[POS_GF1];
            st_d.gf0 = wr_data[POS_GF0];
            st_d.idl = wr_data[POS_IDL] & ~wr_data[POS_PD];
            if (wr_data[POS_PD]) begin
                st_d.pd = 1'b1;
            end
        end
        // a pending interrupt or an active power-down leaves no idle request
        if (wake_irq || st_d.pd) begin
            st_d.idl = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PMC_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data[POS_DBL] = st_q.dbl;
        rd_data[POS_GF1] = st_q.gf1;
        rd_data[POS_GF0] = st_q.gf0;
        rd_data[POS_PD]  = st_q.pd;
        rd_data[POS_IDL] = st_q.idl;
    end

    for (genvar g = RSV_LO; g <= RSV_HI; g++) begin : g_rsv
        assign rd_data[g] = 1'b0;
    end

    pwr_mode_out u_out (
        .st        (st_q),
        .idle_mode (idle_mode),
        .pd_mode   (pd_mode)
    );

    pwr_baud_sel #(.SER_MODE_W(SER_MODE_W)) u_baud (
        .dbl      (st_q.dbl),
        .t1_src   (t1_baud_src),
        .ser_mode (ser_mode),
        .x2       (baud_x2)
    );
endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk #(
    parameter int SER_MODE_W = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_sel,
    input logic                  wr_en,
    input logic [7:0]            rd_data,
    input logic                  wake_irq,
    input logic [SER_MODE_W-1:0] ser_mode,
    input logic                  t1_baud_src,
    input logic                  idle_mode,
    input logic                  pd_mode,
    input logic                  baud_x2
);
    // R9
    mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle_mode && pd_mode));

    // R8
    pd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_mode |=> pd_mode);

    // R7
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !idle_mode && !rd_data[0]);

    // R3
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:4] == 3'b000);

    // R10
    baud_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_x2 == (rd_data[7] && t1_baud_src && (ser_mode != '0)));

    // R11
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_sel && wr_en) && !wake_irq) |=> $stable(rd_data));
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.SER_MODE_W(SER_MODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_sel     (reg_sel),
    .wr_en       (wr_en),
    .rd_data     (rd_data),
    .wake_irq    (wake_irq),
    .ser_mode    (ser_mode),
    .t1_baud_src (t1_baud_src),
    .idle_mode   (idle_mode),
    .pd_mode     (pd_mode),
    .baud_x2     (baud_x2)
);

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SMW        = 2;

    typedef struct {
        logic [7:0] rd;
        logic       idle;
        logic       pd;
        logic       x2;
        string      tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_sel = 1'b0;
    logic           wr_en = 1'b0;
    logic [7:0]     wr_data = 8'h00;
    logic [7:0]     rd_data;
    logic           wake_irq = 1'b0;
    logic [SMW-1:0] ser_mode = '0;
    logic           t1_baud_src = 1'b0;
    logic           idle_mode, pd_mode, baud_x2;

    int   n_checks = 0;
    int   n_errs   = 0;
    exp_t sb_q[$];

    // reference state, written from the requirements
    logic m_dbl = 0, m_gf1 = 0, m_gf0 = 0, m_pd = 0, m_idl = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctl #(.SER_MODE_W(SMW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_sel     (reg_sel),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .wake_irq    (wake_irq),
        .ser_mode    (ser_mode),
        .t1_baud_src (t1_baud_src),
        .idle_mode   (idle_mode),
        .pd_mode     (pd_mode),
        .baud_x2     (baud_x2)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per clock edge, samples 3 time units after the edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                cmp(e.tag, "rd_data",   int'(rd_data),   int'(e.rd));
                cmp(e.tag, "idle_mode", int'(idle_mode), int'(e.idle));
                cmp(e.tag, "pd_mode",   int'(pd_mode),   int'(e.pd));
                cmp(e.tag, "baud_x2",   int'(baud_x2),   int'(e.x2));
            end
        end
    end

    function automatic exp_t model_out(input string tag);
        exp_t e;
        e.rd   = {m_dbl, 3'b000, m_gf1, m_gf0, m_pd, m_idl};
        e.pd   = m_pd;
        e.idle = m_idl && !m_pd;
        e.x2   = m_dbl && t1_baud_src && (ser_mode != 0);
        e.tag  = tag;
        return e;
    endfunction

    // driver: sets inputs at the falling edge, updates the model, queues the result
    task automatic step(input logic sel, input logic we, input logic [7:0] wd,
                        input logic wk, input logic [SMW-1:0] md, input logic t1,
                        input string tag);
        @(negedge clk);
        reg_sel = sel; wr_en = we; wr_data = wd; wake_irq = wk;
        ser_mode = md; t1_baud_src = t1;
        if (!rst_n) begin
            m_dbl = 0; m_gf1 = 0; m_gf0 = 0; m_pd = 0; m_idl = 0;
        end else begin
            if (sel && we) begin
                m_dbl = wd[7]; m_gf1 = wd[3]; m_gf0 = wd[2];
                if (wd[1]) m_pd = 1'b1;
                m_idl = wd[0] && !wd[1];
            end
            if (wk || m_pd) m_idl = 1'b0;
        end
        sb_q.push_back(model_out(tag));
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        // R1: held in reset, even with a write attempt
        step(1, 1, 8'hFF, 0, 2'd1, 1, "R1");
        step(0, 0, 8'h00, 0, 2'd0, 0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 8'h00, 0, 2'd0, 0, "R1");
        // R2: store flags and double-rate bit
        step(1, 1, 8'h8C, 0, 2'd0, 0, "R2");
        step(1, 1, 8'h04, 0, 2'd0, 0, "R2");
        // R3: reserved bits ignored
        step(1, 1, 8'hF8, 0, 2'd0, 0, "R3");
        // R10: baud select over modes and source
        step(0, 0, 8'h00, 0, 2'd0, 1, "R10");
        step(0, 0, 8'h00, 0, 2'd1, 1, "R10");
        step(0, 0, 8'h00, 0, 2'd2, 1, "R10");
        step(0, 0, 8'h00, 0, 2'd3, 0, "R10");
        step(0, 0, 8'h00, 0, 2'd3, 1, "R10");
        // R11: unselected or non-write edges change nothing
        step(0, 1, 8'h0F, 0, 2'd3, 1, "R11");
        step(1, 0, 8'h0F, 0, 2'd3, 1, "R11");
        // R4: enter and leave idle by writes
        step(1, 1, 8'h01, 0, 2'd1, 1, "R4");
        step(0, 0, 8'h00, 0, 2'd1, 1, "R4");
        step(1, 1, 8'h80, 0, 2'd1, 1, "R4");
        step(1, 1, 8'h81, 0, 2'd1, 1, "R4");
        // R7: wake exits idle
        step(0, 0, 8'h00, 1, 2'd1, 1, "R7");
        step(1, 1, 8'h01, 1, 2'd1, 1, "R7");
        step(1, 1, 8'h01, 0, 2'd1, 1, "R7");
        // R6: both bits in one write
        step(1, 1, 8'h03, 0, 2'd1, 1, "R6");
        step(0, 0, 8'h00, 0, 2'd1, 1, "R6");
        // R8: power-down persists
        step(0, 0, 8'h00, 1, 2'd1, 1, "R8");
        step(1, 1, 8'h0D, 0, 2'd1, 1, "R8");
        // R9: both modes stay exclusive in power-down
        step(1, 1, 8'h01, 0, 2'd2, 0, "R9");
        // R1: reset leaves power-down
        @(negedge clk);
        rst_n = 1'b0;
        step(0, 0, 8'h00, 0, 2'd0, 0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 8'h00, 0, 2'd0, 0, "R1");
        // R5: power-down alone
        step(1, 1, 8'h06, 0, 2'd0, 0, "R5");
        step(0, 0, 8'h00, 0, 2'd0, 0, "R5");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule